// File: doc/BRIEF.md
# Scaler Initial Phase Calculator

This block produces the starting filter phase for one axis of a polyphase image scaler. It takes an unsigned 16.16 scale ratio (source extent divided by destination extent), a choice between full-rate and half-rate chroma, and a flag that asks for co-sited chroma samples. From these it forms a signed phase in units where 0x10000 is one pixel. The phase starts half a pixel before the sample centre, so scaling is measured from the pixel edge.

A negative phase is folded into the next pixel and reported with a cleared trip flag. A non-negative phase keeps its value and sets the trip flag. The folded phase is then divided by four and truncated into a 13-bit field, and the trip flag goes into bit 14 of a 16-bit phase word. Results outside the range the filter supports raise an error flag. A request is presented with a one-cycle strobe, and the registered result comes back exactly one clock later with its own strobe.

Top module: `phase_init_calc`

## Requirements
- R1: While reset is asserted and on the first edge after it, out_valid, phase_word and range_err are all zero.
- R2: out_valid is high in exactly the cycles that follow a cycle in which in_valid was high.
- R3: The raw phase equals -0x8000, plus the co-siting offset, plus the scale divided by 2 when sub_two=0 or by 4 when sub_two=1, with truncation toward zero. The co-siting offset is 0x4000 only when sub_two=1 and cosited=1.
- R4: When the raw phase is negative, the folded phase is the raw phase plus 0x10000 and the trip flag (phase_word bit 14) is 0.
- R5: When the raw phase is zero or positive, the folded phase equals the raw phase and the trip flag (phase_word bit 14) is 1.
- R6: phase_word[12:0] holds bits 14:2 of the folded phase. Bits 13 and 15 of phase_word are always 0.
- R7: range_err is 1 exactly when the raw phase is below -0x8000 or above 0x18000. The boundary values themselves are legal.
- R8: With sub_two=0, a scale of 0x40000 (4:1 downscale) gives phase_word 0x4000, and a scale of 0x4000 (1:4 upscale) gives phase_word 0x0800.
- R9: With sub_two=0 the cosited input has no effect on phase_word or range_err.
- R10: In a cycle without in_valid, phase_word and range_err keep their previous values, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; data inputs are sampled when high |
| scale_in | input | SCALE_W | Unsigned 16.16 scale ratio, source over destination |
| sub_two | input | 1 | 0: full-rate samples, 1: half-rate chroma |
| cosited | input | 1 | Apply the co-sited chroma offset (only with sub_two=1) |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| phase_word | output | OUT_W | Packed phase: field in [12:0], trip flag in bit 14 |
| range_err | output | 1 | Raw phase outside -0x8000..0x18000 |

## Verification
Every result (phase_word, range_err and out_valid) comes out of a single register stage, so it is due on the first rising edge after the cycle in which in_valid is high. The bench drives a request on a falling edge and reads the outputs on the next falling edge, half a period after that register edge. It then drops the strobe, changes the data inputs, and reads again one falling edge later to confirm that out_valid has fallen and the result has been held. The sweep covers all four mode combinations over a wide grid of scale values, and adds the exact points where the sign changes and where the range limits are crossed.

// File: rtl/phase_init_pkg.sv
package phase_init_pkg;

  // Working phase type: signed, 0x10000 equals one pixel.
  typedef logic signed [31:0] phase_t;

  localparam phase_t ONE_PIX   = 32'sh0001_0000;
  localparam phase_t HALF_PIX  = 32'sh0000_8000;
  localparam phase_t MIN_PHASE = -32'sh0000_8000;
  localparam phase_t MAX_PHASE = 32'sh0001_8000;

  // Offset that moves the half-rate chroma sample onto the luma grid.
  function automatic phase_t cosite_offset(input logic sub_two, input logic cosited);
    return (sub_two && cosited) ? (HALF_PIX >>> 1) : '0;
  endfunction

  // scale / (2*sub); the operand is never negative, so a shift truncates toward zero.
  function automatic phase_t scale_term(input phase_t scale_ext, input logic sub_two);
    return sub_two ? (scale_ext >>> 2) : (scale_ext >>> 1);
  endfunction

  function automatic logic phase_in_range(input phase_t p);
    return (p >= MIN_PHASE) && (p <= MAX_PHASE);
  endfunction

  function automatic phase_t fold_phase(input phase_t p);
    return (p < 0) ? (p + ONE_PIX) : p;
  endfunction

endpackage

// File: rtl/phase_raw_sum.sv
module phase_raw_sum
  import phase_init_pkg::*;
#(
  parameter int SCALE_W = 20
) (
  input  logic [SCALE_W-1:0] scale,
  input  logic               sub_two,
  input  logic               cosited,
  output phase_t             raw_phase
);
  localparam int PAD_W = 32 - SCALE_W;

  phase_t scale_ext;
  phase_t edge_start;

  assign scale_ext  = phase_t'({{PAD_W{1'b0}}, scale});
  assign edge_start = MIN_PHASE + cosite_offset(sub_two, cosited);
  assign raw_phase  = edge_start + scale_term(scale_ext, sub_two);
endmodule

// File: rtl/phase_fold.sv
module phase_fold
  import phase_init_pkg::*;
(
  input  phase_t raw_phase,
  output phase_t folded,
  output logic   trip,
  output logic   out_of_range
);
  assign folded       = fold_phase(raw_phase);
  assign trip         = (raw_phase >= 0);
  assign out_of_range = !phase_in_range(raw_phase);
endmodule

// File: rtl/phase_pack.sv
module phase_pack
  import phase_init_pkg::*;
#(
  parameter int OUT_W       = 16,
  parameter int FIELD_W     = 13,
  parameter int FIELD_SHIFT = 2,
  parameter int TRIP_POS    = 14
) (
  input  phase_t           folded,
  input  logic             trip,
  output logic [OUT_W-1:0] word
);
  localparam logic [31:0] FIELD_MASK = (32'd1 << FIELD_W) - 32'd1;

  logic [OUT_W-1:0] field_bits;
  logic [OUT_W-1:0] trip_bits;

  assign field_bits = OUT_W'((folded >>> FIELD_SHIFT) & FIELD_MASK);

  generate
    if (TRIP_POS < OUT_W) begin : g_trip_in_word
      assign trip_bits = OUT_W'(trip) << TRIP_POS;
    end else begin : g_trip_dropped
      assign trip_bits = '0;
    end
  endgenerate

  assign word = field_bits | trip_bits;
endmodule

// File: rtl/phase_init_calc.sv
module phase_init_calc
  import phase_init_pkg::*;
#(
  parameter int SCALE_W     = 20,
  parameter int OUT_W       = 16,
  parameter int FIELD_W     = 13,
  parameter int FIELD_SHIFT = 2,
  parameter int TRIP_POS    = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [SCALE_W-1:0] scale_in,
  input  logic               sub_two,
  input  logic               cosited,
  output logic               out_valid,
  output logic [OUT_W-1:0]   phase_word,
  output logic               range_err
);
  // Named internal events, visible to the bound checker.
  phase_t           raw_phase;
  phase_t           folded_phase;
  logic             fold_trip;
  logic             fold_err;
  logic [OUT_W-1:0] packed_word;

  phase_raw_sum #(.SCALE_W(SCALE_W)) u_sum (
    .scale     (scale_in),
    .sub_two   (sub_two),
    .cosited   (cosited),
    .raw_phase (raw_phase)
  );

  phase_fold u_fold (
    .raw_phase    (raw_phase),
    .folded       (folded_phase),
    .trip         (fold_trip),
    .out_of_range (fold_err)
  );

  phase_pack #(
    .OUT_W       (OUT_W),
    .FIELD_W     (FIELD_W),
    .FIELD_SHIFT (FIELD_SHIFT),
    .TRIP_POS    (TRIP_POS)
  ) u_pack (
    .folded (folded_phase),
    .trip   (fold_trip),
    .word   (packed_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      phase_word <= '0;
      range_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        phase_word <= packed_word;
        range_err  <= fold_err;
      end
    end
  end
endmodule

// File: rtl/phase_init_calc_chk.sv
module phase_init_calc_chk
  import phase_init_pkg::*;
#(
  parameter int OUT_W    = 16,
  parameter int TRIP_POS = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] phase_word,
  input logic             range_err,
  input phase_t           raw_phase,
  input logic             fold_trip
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phase_word) && $stable(range_err))); // R10

  AST_TRIP_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    fold_trip == !raw_phase[31]); // R5

  AST_TRIP_REACHES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (phase_word[TRIP_POS] == $past(!raw_phase[31]))); // R4

  AST_ERR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (range_err == $past((raw_phase > MAX_PHASE) || (raw_phase < MIN_PHASE)))); // R7

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (phase_word[13] == 1'b0 && phase_word[15] == 1'b0)); // R6
endmodule

bind phase_init_calc phase_init_calc_chk #(
  .OUT_W    (OUT_W),
  .TRIP_POS (TRIP_POS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .phase_word (phase_word),
  .range_err  (range_err),
  .raw_phase  (raw_phase),
  .fold_trip  (fold_trip)
);

// File: tb/tb_phase_init_calc.sv
module tb_phase_init_calc;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [19:0] scale_in = '0;
  logic        sub_two = 1'b0;
  logic        cosited = 1'b0;
  logic        out_valid;
  logic [15:0] phase_word;
  logic        range_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_init_calc dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .scale_in   (scale_in),
    .sub_two    (sub_two),
    .cosited    (cosited),
    .out_valid  (out_valid),
    .phase_word (phase_word),
    .range_err  (range_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (scale=0x%0h sub_two=%0d cosited=%0d)",
               req, act, exp, scale_in, sub_two, cosited);
    end
  endtask

  // Independent model written with integer division and modulo.
  function automatic int model_raw(input int s, input int sub, input bit cos);
    int r = -32768;
    if (cos) r = r + ((sub - 1) * 32768) / sub;
    return r + s / (2 * sub);
  endfunction

  function automatic int model_word(input int raw);
    int f = raw;
    int t = 1;
    if (raw < 0) begin
      f = raw + 65536;
      t = 0;
    end
    return ((f / 4) % 8192) + t * 16384;
  endfunction

  // One request: strobe, read result, drop strobe with disturbed inputs, read hold.
  task automatic apply(input int s, input bit two, input bit cos, input string tag);
    int raw;
    int ew;
    int ee;
    logic [15:0] w;
    logic        e;
    raw = model_raw(s, two ? 2 : 1, cos);
    ew  = model_word(raw);
    ee  = (raw < -32768 || raw > 98304) ? 1 : 0;
    @(negedge clk);
    scale_in = 20'(s); sub_two = two; cosited = cos; in_valid = 1'b1;
    @(negedge clk);
    check("R2 out_valid after strobe", int'(out_valid), 1);
    if (raw < 0) check({"R4 ", tag}, int'(phase_word), ew);
    else         check({"R5 ", tag}, int'(phase_word), ew);
    check("R3/R6 packed field", int'(phase_word[12:0]), ew % 16384);
    check("R6 spare bits", int'({phase_word[15], phase_word[13]}), 0);
    check("R7 range_err", int'(range_err), ee);
    if (!two && cos) check("R9 cosited ignored", int'(phase_word), ew);
    w = phase_word; e = range_err;
    in_valid = 1'b0; scale_in = ~scale_in; sub_two = ~two; cosited = ~cos;
    @(negedge clk);
    check("R2 out_valid drops", int'(out_valid), 0);
    check("R10 hold", int'({e, w}), int'({range_err, phase_word}));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 phase_word in reset", int'(phase_word), 0);
    check("R1 range_err in reset", int'(range_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 phase_word after reset", int'(phase_word), 0);

    // R8 worked examples
    apply(32'h40000, 1'b0, 1'b0, "R8 4:1 downscale");
    check("R8 4:1 downscale word", int'(phase_word), 32'h4000);
    apply(32'h04000, 1'b0, 1'b0, "R8 1:4 upscale");
    check("R8 1:4 upscale word", int'(phase_word), 32'h0800);

    // Sign and range boundaries in every mode (R3, R4, R5, R7)
    apply(32'h0FFFF, 1'b0, 1'b0, "R4 just negative");
    apply(32'h10000, 1'b0, 1'b0, "R5 zero phase");
    apply(32'h40001, 1'b0, 1'b0, "R7 top edge");
    apply(32'h40002, 1'b0, 1'b0, "R7 above top");
    apply(32'h0FFFF, 1'b1, 1'b1, "R3 cosited neg");
    apply(32'h10000, 1'b1, 1'b1, "R3 cosited zero");
    apply(32'h70003, 1'b1, 1'b1, "R7 cosited top edge");
    apply(32'h70004, 1'b1, 1'b1, "R7 cosited above top");
    apply(32'h1FFFF, 1'b1, 1'b0, "R4 half-rate neg");
    apply(32'h20000, 1'b1, 1'b0, "R5 half-rate zero");
    apply(32'h00000, 1'b0, 1'b1, "R9 zero scale");
    apply(32'hFFFFF, 1'b1, 1'b0, "R7 largest scale");

    // Grid sweep over all four mode combinations
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 4096; k++) begin
        apply(k * 256 + (k % 7), m[1], m[0], "R3 sweep");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule